// File: doc/BRIEF.md
# Memory-Type Range Configuration Register File

This block holds the configuration that tells a memory-type lookup how each physical address region may be cached. It keeps a default-type control word, a page-attribute word, eleven fixed-range words and a parameterised number of variable-range base/mask pairs. Each fixed-range word packs eight one-byte type fields. The first fixed word covers eight 64 KB granules from address 0. The next two cover 16 KB granules from 0x80000. The last eight cover 4 KB granules from 0xC0000.

Every write arrives as an address/data pair qualified by a strobe. It is checked byte by byte against the legal encodings for its register kind and against that register's reserved-bit mask. A legal write is committed and acknowledged. Any other write is answered with a fault and changes nothing. A separate read port returns stored words and a read-only capability word. The default-type fields are brought out directly for the lookup logic.

The physical address width and the number of variable pairs are parameters. Both set the reserved-bit masks and the decoded address set.

Top module: `mtcfg_regfile`

## Requirements
- R1: After reset every stored word reads as zero, all response outputs are low and the global enable output is off.
- R2: A range-type byte is legal only for values 0, 1, 4, 5 and 6. A write to a fixed-range word (addresses 0x250 to 0x25A) is accepted only if all eight bytes are legal range types.
- R3: A page-attribute byte is legal for values 0, 1, 4, 5, 6 and 7. A write to the page-attribute word (address 0x277) is accepted only if all eight bytes are legal.
- R4: A write to the default-type word (address 0x2FF) faults if any bit outside 0xCFF is set, or if bits 7:0 are not a legal range type.
- R5: A write to a variable base faults if any of bits 11:8 is set, if any bit at or above PA_W is set, or if bits 7:0 are not a legal range type.
- R6: A write to a variable mask faults if any of bits 10:0 is set, or if any bit at or above PA_W is set.
- R7: Address 0x0FE reads as 0x500 OR NVAR with no fault. Any write to it faults.
- R8: A read or write to an address outside the decoded set faults. A faulting read returns zero data.
- R9: A faulted write leaves every stored word and every configuration output unchanged.
- R10: Each write strobe gets exactly one of accept or fault, registered one cycle later. A read strobe gets its data and status one cycle later. A cycle without a strobe gives no response.
- R11: Pair i sits at 0x200+2i for the base and 0x201+2i for the mask. Each address reads back only what was last accepted there.
- R12: The enable outputs show bit 11 (global) and bit 10 (fixed-range) of the default-type word, and the type output shows bits 7:0. They change on the edge that commits the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | 1 | Write strobe |
| wr_addr | input | 12 | Write register address |
| wr_data | input | 64 | Write data |
| wr_ack | output | 1 | Write accepted and committed (one cycle after strobe) |
| wr_flt | output | 1 | Write refused (one cycle after strobe) |
| rd_vld | input | 1 | Read strobe |
| rd_addr | input | 12 | Read register address |
| rd_done | output | 1 | Read response valid |
| rd_data | output | 64 | Read data, zero when no read or on fault |
| rd_flt | output | 1 | Read of an undecoded address |
| cfg_en | output | 1 | Global enable field |
| cfg_fix_en | output | 1 | Fixed-range enable field |
| cfg_dflt | output | 8 | Default memory type field |

## Verification
A write's accept/fault pair is due on the first rising edge after the strobe, and the write commits on that same edge. Read data and read status are also due one edge after the read strobe. That data reflects the state before any write committed on the same edge. The configuration outputs take their new value on the committing edge. The bench applies stimulus at the falling edge and updates its model at the rising edge. It compares every output at the next falling edge, so each check samples exactly one register stage after its stimulus.

// File: rtl/mtcfg_pkg.sv
`timescale 1ns/1ps
package mtcfg_pkg;

  localparam int XLEN   = 64;
  localparam int ADDR_W = 12;
  localparam int NFIX   = 11;

  localparam logic [ADDR_W-1:0] VAR_BASE = 12'h200;
  localparam logic [ADDR_W-1:0] FIX_BASE = 12'h250;
  localparam logic [ADDR_W-1:0] PAT_ADDR = 12'h277;
  localparam logic [ADDR_W-1:0] DEF_ADDR = 12'h2FF;
  localparam logic [ADDR_W-1:0] CAP_ADDR = 12'h0FE;

  localparam logic [XLEN-1:0] DEF_KEEP     = 64'hCFF;
  localparam logic [XLEN-1:0] BASE_LOW_RSV = 64'hF00;
  localparam logic [XLEN-1:0] MASK_LOW_RSV = 64'h7FF;
  localparam logic [XLEN-1:0] CAP_FLAGS    = 64'h500;

  typedef enum logic [2:0] {
    RK_NONE, RK_CAP, RK_DEF, RK_PAT, RK_FIX, RK_VBASE, RK_VMASK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  function automatic logic rt_legal(input logic [7:0] b);
    case (b)
      8'd0, 8'd1, 8'd4, 8'd5, 8'd6: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic pa_legal(input logic [7:0] b);
    return rt_legal(b) || (b == 8'd7);
  endfunction

endpackage

// File: rtl/mtcfg_decode.sv
`timescale 1ns/1ps
module mtcfg_decode
  import mtcfg_pkg::*;
#(
  parameter int NVAR = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam logic [ADDR_W-1:0] VAR_SPAN = ADDR_W'(2 * NVAR);
  localparam logic [ADDR_W-1:0] FIX_SPAN = ADDR_W'(NFIX);

  logic [ADDR_W-1:0] var_off;
  logic [ADDR_W-1:0] fix_off;

  assign var_off = addr - VAR_BASE;
  assign fix_off = addr - FIX_BASE;

  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    if (addr >= VAR_BASE && var_off < VAR_SPAN) begin
      sel.kind = var_off[0] ? RK_VMASK : RK_VBASE;
      sel.idx  = var_off[8:1];
    end else if (addr >= FIX_BASE && fix_off < FIX_SPAN) begin
      sel.kind = RK_FIX;
      sel.idx  = fix_off[7:0];
    end else if (addr == PAT_ADDR) begin
      sel.kind = RK_PAT;
    end else if (addr == DEF_ADDR) begin
      sel.kind = RK_DEF;
    end else if (addr == CAP_ADDR) begin
      sel.kind = RK_CAP;
    end
  end

endmodule

// File: rtl/mtcfg_check.sv
`timescale 1ns/1ps
module mtcfg_check
  import mtcfg_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  reg_kind_e       kind,
  input  logic [XLEN-1:0] data,
  output logic            ok
);

  localparam int NLANE = XLEN / 8;
  localparam logic [XLEN-1:0] HI_RSV = {XLEN{1'b1}} << PA_W;

  logic [NLANE-1:0] rt_ok;
  logic [NLANE-1:0] pa_ok;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign rt_ok[b] = rt_legal(data[8*b +: 8]);
    assign pa_ok[b] = pa_legal(data[8*b +: 8]);
  end

  always_comb begin
    ok = 1'b0;
    case (kind)
      RK_DEF:   ok = ((data & ~DEF_KEEP) == '0) && rt_ok[0];
      RK_PAT:   ok = &pa_ok;
      RK_FIX:   ok = &rt_ok;
      RK_VBASE: ok = ((data & (HI_RSV | BASE_LOW_RSV)) == '0) && rt_ok[0];
      RK_VMASK: ok = ((data & (HI_RSV | MASK_LOW_RSV)) == '0);
      default:  ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/mtcfg_store.sv
`timescale 1ns/1ps
module mtcfg_store
  import mtcfg_pkg::*;
#(
  parameter int NVAR = 8,
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  reg_sel_t        wsel,
  input  logic [XLEN-1:0] wdata,
  input  reg_sel_t        rsel,
  output logic [XLEN-1:0] rdata,
  output logic            en_glb,
  output logic            en_fix,
  output logic [7:0]      dflt_type
);

  localparam logic [XLEN-1:0] HI_RSV = {XLEN{1'b1}} << PA_W;

  logic [XLEN-1:0] def_q, def_d;
  logic [XLEN-1:0] pat_q, pat_d;
  logic [XLEN-1:0] fix_q [NFIX];
  logic [XLEN-1:0] fix_d [NFIX];
  logic [XLEN-1:0] vb_q  [NVAR];
  logic [XLEN-1:0] vb_d  [NVAR];
  logic [XLEN-1:0] vm_q  [NVAR];
  logic [XLEN-1:0] vm_d  [NVAR];

  // single words: next state
  always_comb begin
    def_d = def_q;
    pat_d = pat_q;
    if (we && wsel.kind == RK_DEF) def_d = wdata;
    if (we && wsel.kind == RK_PAT) pat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q <= '0;
      pat_q <= '0;
    end else begin
      def_q <= def_d;
      pat_q <= pat_d;
    end
  end

  // fixed-range words
  for (genvar k = 0; k < NFIX; k++) begin : g_fix
    always_comb begin
      fix_d[k] = fix_q[k];
      if (we && wsel.kind == RK_FIX && wsel.idx == 8'(k)) fix_d[k] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fix_q[k] <= '0;
      else        fix_q[k] <= fix_d[k];
    end
  end

  // variable pairs
  for (genvar i = 0; i < NVAR; i++) begin : g_var
    always_comb begin
      vb_d[i] = vb_q[i];
      vm_d[i] = vm_q[i];
      if (we && wsel.idx == 8'(i)) begin
        if (wsel.kind == RK_VBASE) vb_d[i] = wdata;
        if (wsel.kind == RK_VMASK) vm_d[i] = wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vb_q[i] <= '0;
        vm_q[i] <= '0;
      end else begin
        vb_q[i] <= vb_d[i];
        vm_q[i] <= vm_d[i];
      end
    end

    AST_VBASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      ((vb_q[i] & (HI_RSV | BASE_LOW_RSV)) == '0) && rt_legal(vb_q[i][7:0])); // R5
    AST_VMASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_q[i] & (HI_RSV | MASK_LOW_RSV)) == '0); // R6
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (rsel.kind)
      RK_DEF: rdata = def_q;
      RK_PAT: rdata = pat_q;
      RK_FIX: begin
        for (int k = 0; k < NFIX; k++)
          if (rsel.idx == 8'(k)) rdata = fix_q[k];
      end
      RK_VBASE: begin
        for (int i = 0; i < NVAR; i++)
          if (rsel.idx == 8'(i)) rdata = vb_q[i];
      end
      RK_VMASK: begin
        for (int i = 0; i < NVAR; i++)
          if (rsel.idx == 8'(i)) rdata = vm_q[i];
      end
      default: rdata = '0;
    endcase
  end

  assign en_glb    = def_q[11];
  assign en_fix    = def_q[10];
  assign dflt_type = def_q[7:0];

  AST_DEF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((def_q & ~DEF_KEEP) == '0) && rt_legal(def_q[7:0])); // R4
  AST_PAT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pa_legal(pat_q[7:0]) && pa_legal(pat_q[63:56])); // R3

endmodule

// File: rtl/mtcfg_regfile.sv
`timescale 1ns/1ps
module mtcfg_regfile
  import mtcfg_pkg::*;
#(
  parameter int NVAR = 8,
  parameter int PA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  output logic              wr_ack,
  output logic              wr_flt,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [XLEN-1:0]   rd_data,
  output logic              rd_flt,
  output logic              cfg_en,
  output logic              cfg_fix_en,
  output logic [7:0]        cfg_dflt
);

  localparam logic [XLEN-1:0] CAP_WORD = CAP_FLAGS | XLEN'(NVAR);

  reg_sel_t        wr_sel;
  reg_sel_t        rd_sel;
  logic            wr_legal;
  logic            commit;
  logic [XLEN-1:0] store_rdata;
  logic [XLEN-1:0] rd_val;
  logic            rd_hit;

  logic            ack_d, flt_d, ack_q, flt_q;
  logic            rdone_d, rflt_d, rdone_q, rflt_q;
  logic [XLEN-1:0] rdata_d, rdata_q;

  mtcfg_decode #(.NVAR(NVAR)) u_wdec (.addr(wr_addr), .sel(wr_sel));
  mtcfg_decode #(.NVAR(NVAR)) u_rdec (.addr(rd_addr), .sel(rd_sel));

  mtcfg_check #(.PA_W(PA_W)) u_check (
    .kind (wr_sel.kind),
    .data (wr_data),
    .ok   (wr_legal)
  );

  assign commit = wr_vld && wr_legal;

  mtcfg_store #(.NVAR(NVAR), .PA_W(PA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (commit),
    .wsel      (wr_sel),
    .wdata     (wr_data),
    .rsel      (rd_sel),
    .rdata     (store_rdata),
    .en_glb    (cfg_en),
    .en_fix    (cfg_fix_en),
    .dflt_type (cfg_dflt)
  );

  // response next state
  always_comb begin
    rd_hit  = (rd_sel.kind != RK_NONE);
    rd_val  = (rd_sel.kind == RK_CAP) ? CAP_WORD : store_rdata;
    ack_d   = commit;
    flt_d   = wr_vld && !wr_legal;
    rdone_d = rd_vld;
    rflt_d  = rd_vld && !rd_hit;
    rdata_d = (rd_vld && rd_hit) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      flt_q   <= 1'b0;
      rdone_q <= 1'b0;
      rflt_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      flt_q   <= flt_d;
      rdone_q <= rdone_d;
      rflt_q  <= rflt_d;
      rdata_q <= rdata_d;
    end
  end

  assign wr_ack  = ack_q;
  assign wr_flt  = flt_q;
  assign rd_done = rdone_q;
  assign rd_flt  = rflt_q;
  assign rd_data = rdata_q;

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && wr_flt)); // R10
  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> (wr_ack || wr_flt)); // R10
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> !(wr_ack || wr_flt)); // R10
  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flt |-> $stable({cfg_en, cfg_fix_en, cfg_dflt})); // R9
  AST_CAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_addr == CAP_ADDR) |=> (rd_data == CAP_WORD && !rd_flt)); // R7
  AST_CAP_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_addr == CAP_ADDR) |=> wr_flt); // R7
  AST_RD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flt |-> (rd_done && rd_data == '0)); // R8

endmodule

// File: tb/test_mtcfg_regfile.sv
`timescale 1ns/1ps
module test_mtcfg_regfile;

  localparam int NVAR = 8;
  localparam int PA_W = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_vld = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_vld = 1'b0;
  logic [11:0] rd_addr = '0;
  logic        wr_ack, wr_flt, rd_done, rd_flt, cfg_en, cfg_fix_en;
  logic [63:0] rd_data;
  logic [7:0]  cfg_dflt;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  logic [63:0] m_def, m_pat;
  logic [63:0] m_fix [11];
  logic [63:0] m_vb  [NVAR];
  logic [63:0] m_vm  [NVAR];

  always #2.5 clk = ~clk;

  mtcfg_regfile #(.NVAR(NVAR), .PA_W(PA_W)) i_mtcfg_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_flt(wr_flt),
    .rd_vld(rd_vld), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .rd_flt(rd_flt),
    .cfg_en(cfg_en), .cfg_fix_en(cfg_fix_en), .cfg_dflt(cfg_dflt)
  );

  function automatic bit rt_ok(input logic [7:0] b);
    return (b < 8) && (((8'h73 >> b) & 8'h1) != 0);
  endfunction

  function automatic bit pa_ok(input logic [7:0] b);
    return (b < 8) && (((8'hF3 >> b) & 8'h1) != 0);
  endfunction

  function automatic bit all_bytes(input logic [63:0] d, input bit pat);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] v = d[8*b +: 8];
      if (pat ? !pa_ok(v) : !rt_ok(v)) return 0;
    end
    return 1;
  endfunction

  function automatic bit ref_ok(input int a, input logic [63:0] d);
    if (a >= 'h200 && a < 'h200 + 2*NVAR) begin
      if ((a % 2) == 0)
        return ((d >> 8) & 64'hF) == 0 && (d >> PA_W) == 0 && rt_ok(d[7:0]);
      return (d & 64'h7FF) == 0 && (d >> PA_W) == 0;
    end
    if (a >= 'h250 && a <= 'h25A) return all_bytes(d, 0);
    if (a == 'h277) return all_bytes(d, 1);
    if (a == 'h2FF) return (d & ~64'hCFF) == 0 && rt_ok(d[7:0]);
    return 0;
  endfunction

  task automatic ref_read(input int a, output logic [63:0] v, output bit ok);
    ok = 1; v = '0;
    if (a >= 'h200 && a < 'h200 + 2*NVAR)
      v = ((a % 2) == 0) ? m_vb[(a - 'h200) / 2] : m_vm[(a - 'h200) / 2];
    else if (a >= 'h250 && a <= 'h25A) v = m_fix[a - 'h250];
    else if (a == 'h277) v = m_pat;
    else if (a == 'h2FF) v = m_def;
    else if (a == 'h0FE) v = 64'h500 | 64'(NVAR);
    else ok = 0;
  endtask

  task automatic ref_write(input int a, input logic [63:0] d);
    if (a >= 'h200 && a < 'h200 + 2*NVAR) begin
      if ((a % 2) == 0) m_vb[(a - 'h200) / 2] = d;
      else              m_vm[(a - 'h200) / 2] = d;
    end else if (a >= 'h250 && a <= 'h25A) m_fix[a - 'h250] = d;
    else if (a == 'h277) m_pat = d;
    else if (a == 'h2FF) m_def = d;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit wv, input int wa, input logic [63:0] wd,
                      input bit rv, input int ra, input string tag);
    bit e_ack, e_rok;
    logic [63:0] e_rv;
    wr_vld = wv; wr_addr = 12'(wa); wr_data = wd;
    rd_vld = rv; rd_addr = 12'(ra);
    e_ack = wv && ref_ok(wa, wd);
    ref_read(ra, e_rv, e_rok);
    @(posedge clk);
    if (e_ack) ref_write(wa, wd);
    @(negedge clk);
    chk(tag, "wr_ack/wr_flt", {62'd0, wr_ack, wr_flt}, {62'd0, e_ack, wv && !e_ack});
    chk(tag, "rd_done/rd_flt", {62'd0, rd_done, rd_flt}, {62'd0, rv, rv && !e_rok});
    chk(tag, "rd_data", rd_data, (rv && e_rok) ? e_rv : 64'd0);
    chk("R12", "cfg", {54'd0, cfg_en, cfg_fix_en, cfg_dflt},
        {54'd0, m_def[11], m_def[10], m_def[7:0]});
  endtask

  task automatic wr(input int a, input logic [63:0] d, input string tag);
    step(1, a, d, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 64'd0, 1, a, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int addr_pool [8] = '{'h200, 'h201, 'h20F, 'h250, 'h25A, 'h277, 'h2FF, 'h0FE};

  initial begin
    m_def = '0; m_pat = '0;
    for (int k = 0; k < 11; k++) m_fix[k] = '0;
    for (int i = 0; i < NVAR; i++) begin m_vb[i] = '0; m_vm[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "resp", {60'd0, wr_ack, wr_flt, rd_done, rd_flt}, 64'd0);
    chk("R1", "cfg_en", {63'd0, cfg_en}, 64'd0);
    rd('h2FF, "R1"); rd('h277, "R1"); rd('h250, "R1"); rd('h200, "R1"); rd('h201, "R1");

    // R7: capability word
    rd('h0FE, "R7");
    wr('h0FE, 64'h1, "R7");
    rd('h0FE, "R7");

    // R2: fixed-range writes
    wr('h250, 64'h0605_0401_0001_0406, "R2");
    rd('h250, "R2");
    wr('h251, 64'h0000_0000_0002_0000, "R2");
    wr('h25A, 64'h0700_0000_0000_0000, "R2");
    wr('h25A, 64'h0106_0504_0100_0605, "R2");
    rd('h25A, "R2"); rd('h251, "R2");

    // R3: page attribute
    wr('h277, 64'h0706_0504_0100_0706, "R3");
    wr('h277, 64'h0007_0603_0000_0000, "R3");
    wr('h277, 64'h0000_0000_0000_0008, "R3");
    rd('h277, "R3");

    // R4 / R12: default-type word
    wr('h2FF, 64'h0000_0000_0000_0C06, "R4");
    wr('h2FF, 64'h0000_0000_0000_1C06, "R4");
    wr('h2FF, 64'h0000_0000_0000_0C02, "R4");
    wr('h2FF, 64'h0000_0000_0000_0100, "R4");
    wr('h2FF, 64'h0000_0000_0000_0805, "R12");
    rd('h2FF, "R4");

    // R5: variable base
    wr('h206, 64'h0000_000F_FFFF_F006, "R5");
    wr('h206, 64'h0000_0010_0000_0000, "R5");
    wr('h206, 64'h0000_0000_0000_0100, "R5");
    wr('h206, 64'h0000_0000_0000_0003, "R5");
    // R6: variable mask
    wr('h207, 64'h0000_000F_FFFF_F800, "R6");
    wr('h207, 64'h0000_000F_FFFF_F801, "R6");
    wr('h207, 64'h0000_0100_0000_0800, "R6");
    // R11: pair addressing
    rd('h206, "R11"); rd('h207, "R11"); rd('h204, "R11"); rd('h209, "R11");
    wr('h20F, 64'h0000_0000_8000_0800, "R11");
    rd('h20F, "R11");

    // R8: undecoded addresses
    wr('h300, 64'h0, "R8");
    wr('h210, 64'h0, "R8");
    rd('h300, "R8"); rd('h210, "R8"); rd('h25B, "R8");
    // R9: faulted writes left state intact
    wr('h2FF, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    rd('h2FF, "R9"); rd('h206, "R9");

    // R10: simultaneous read and write of the same word sees the old value
    step(1, 'h250, 64'h0101_0101_0101_0101, 1, 'h250, "R10");
    rd('h250, "R10");
    step(0, 0, 64'd0, 0, 0, "R10");

    // R10: mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'($urandom % 8);
      if ((n % 3) == 0) d = d & 64'h0000_000F_FFFF_F0FF;
      if ((n % 5) == 0) d = d & 64'h0000_000F_FFFF_F800;
      if ((n % 7) == 0) d = d & 64'h0000_0000_0000_0CFF;
      step(($urandom % 4) != 0, addr_pool[$urandom % 8], d,
           ($urandom % 2) != 0, addr_pool[$urandom % 8], "R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule